// File: doc/BRIEF.md
# E3 Frame Alignment Loss Supervisor

This block watches frame alignment for a received E3 stream built from 125 µs frames. An alignment-pattern checker upstream gives one indication per frame boundary: it says whether the two alignment octets sat at the position the current alignment predicts. From these indications the supervisor moves between four states: hunting, confirming, aligned and out-of-frame. It also drives level outputs for the out-of-frame (OOF) and loss-of-frame (LOF) conditions.

After alignment has been lost, the supervisor keeps the last alignment for a limited number of frames. During that time overhead and payload octets can still be located. If recovery does not come in time, the supervisor declares LOF, drops the alignment and starts hunting again. A configuration bit sets the limit to 8 or 24 frames. Level changes are logged in an interrupt status register that clears on read. Each flag has an enable bit, and the enabled flags combine into one interrupt line. A small register port carries the configuration, the enables, the status flags and the live condition levels.

Top module: `e3_align_supervisor`

## Requirements
- R1: After reset the block is hunting. `oof_o`=1, `lof_o`=1, `align_hold`=0 and `irq_o`=0. The flag register (address 2), the enable register (address 1) and the limit-select bit (address 0, bit 7) all read 0.
- R2: While hunting, one frame tick with `fa_ok`=1 moves the block to confirming. A second consecutive tick with `fa_ok`=1 reaches the aligned state, clears `oof_o` and `lof_o`, and sets `align_hold`. A tick with `fa_ok`=0 while confirming returns the block to hunting.
- R3: While aligned, a single tick with `fa_ok`=0 changes nothing. Two consecutive ticks with `fa_ok`=0 enter out-of-frame: `oof_o` goes to 1 and `align_hold` stays 1, because the old alignment is kept.
- R4: While out-of-frame, any tick with `fa_ok`=1 returns the block to aligned and clears `oof_o`.
- R5: The frame limit L is 24 when address 0 bit 7 is 0, and 8 when it is 1. Out-of-frame ticks with `fa_ok`=0 are counted from zero at every entry to out-of-frame. If the L-th such tick arrives without recovery, LOF is declared. Recovery on tick L still avoids LOF.
- R6: Declaring LOF sets `lof_o`=1, clears `align_hold` and returns the block to hunting. `oof_o` stays 1, and `lof_o` is never 1 while `oof_o` is 0.
- R7: The flags at address 2 are set by these events: bit 3 on every change of `oof_o`; bit 2 on every change of `lof_o`; bit 1 on every change of `los_in`; bit 0 on every change of `ais_in`; bit 4 when the aligned state is reached from confirming with `pos_moved`=1.
- R8: Reading address 2 (`reg_re`=1) returns the flags and clears them at that clock edge. A flag whose event falls on that same edge stays set. Bits 7:5 read 0, and writes to address 2 have no effect.
- R9: Address 1 bits 4:0 hold the enables and bits 7:5 read 0. `irq_o` is 1 exactly when some flag is set and its enable bit is also set.
- R10: Address 0 reads as follows: bit 7 is the limit select (read/write); bit 6 is `lof_o`; bit 5 is `oof_o`; bit 4 is `los_in`; bit 3 is `ais_in`; bit 2 is `pldu_in`; bit 1 is `tmark_in`; bit 0 is `ferf_in`. Bits 4 and 3 are sampled one cycle late, and bits 2:0 are live.
- R11: `oof_o` and `lof_o` change only at a clock edge on which `frm_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_tick | input | 1 | One-cycle pulse at each frame boundary |
| fa_ok | input | 1 | Alignment octets found at the expected position (valid with frm_tick) |
| pos_moved | input | 1 | New alignment differs from the last one held (valid with frm_tick) |
| los_in | input | 1 | Loss-of-signal level |
| ais_in | input | 1 | Alarm-indication level |
| pldu_in | input | 1 | Payload-unstable level |
| tmark_in | input | 1 | Timing-marker level |
| ferf_in | input | 1 | Far-end receive failure level |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| oof_o | output | 1 | Out-of-frame level |
| lof_o | output | 1 | Loss-of-frame level |
| align_hold | output | 1 | A frame alignment is held and in use |
| irq_o | output | 1 | Enabled-flag interrupt |

## Verification
A read of the flag register can land on the same edge as a frame tick that changes a level. When that happens, the clear and the new set compete for the same flag bit. The bench issues the read together with the second errored tick while aligned. It expects the read data to show the flags as they were before the edge, `oof_o` to rise, and bit 3 to be set on the next read with the interrupt raised. A second overlap arises at the LOF boundary, where the last permitted recovery and the declaration are one tick apart. The bench drives both sides of that boundary for each limit setting.

// File: rtl/e3_align_supervisor.sv
module e3_align_supervisor #(
  parameter int LIM_LONG  = 24,
  parameter int LIM_SHORT = 8,
  localparam int CW = $clog2(LIM_LONG + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_tick,
  input  logic       fa_ok,
  input  logic       pos_moved,
  input  logic       los_in,
  input  logic       ais_in,
  input  logic       pldu_in,
  input  logic       tmark_in,
  input  logic       ferf_in,
  input  logic       reg_we,
  input  logic       reg_re,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       oof_o,
  output logic       lof_o,
  output logic       align_hold,
  output logic       irq_o
);

  localparam logic [CW-1:0] LONG_M1  = CW'(LIM_LONG - 1);
  localparam logic [CW-1:0] SHORT_M1 = CW'(LIM_SHORT - 1);

  typedef enum logic [1:0] {ST_HUNT, ST_CONF, ST_LOCK, ST_OOF} st_t;

  st_t           st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          err_q, err_n;
  logic          oof_n, lof_n;
  logic          cofa_ev;
  logic          los_q, ais_q;
  logic          lim_sel;
  logic [4:0]    ien, flags;
  logic [4:0]    ev;
  logic          rd_clr;
  logic          unused_wd;

  wire [CW-1:0] lim_m1 = lim_sel ? SHORT_M1 : LONG_M1;

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    err_n   = err_q;
    oof_n   = oof_o;
    lof_n   = lof_o;
    cofa_ev = 1'b0;
    if (frm_tick) begin
      case (st)
        ST_HUNT: if (fa_ok) st_n = ST_CONF;
        ST_CONF: begin
          if (fa_ok) begin
            st_n    = ST_LOCK;
            oof_n   = 1'b0;
            lof_n   = 1'b0;
            err_n   = 1'b0;
            cofa_ev = pos_moved;
          end else begin
            st_n = ST_HUNT;
          end
        end
        ST_LOCK: begin
          if (fa_ok) begin
            err_n = 1'b0;
          end else if (err_q) begin
            st_n  = ST_OOF;
            oof_n = 1'b1;
            cnt_n = '0;
            err_n = 1'b0;
          end else begin
            err_n = 1'b1;
          end
        end
        ST_OOF: begin
          if (fa_ok) begin
            st_n  = ST_LOCK;
            oof_n = 1'b0;
          end else if (cnt == lim_m1) begin
            st_n  = ST_HUNT;
            lof_n = 1'b1;
            cnt_n = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign ev     = {cofa_ev, oof_n != oof_o, lof_n != lof_o, los_in != los_q, ais_in != ais_q};
  assign rd_clr = reg_re && (reg_addr == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_HUNT;
      cnt     <= '0;
      err_q   <= 1'b0;
      oof_o   <= 1'b1;
      lof_o   <= 1'b1;
      los_q   <= 1'b0;
      ais_q   <= 1'b0;
      lim_sel <= 1'b0;
      ien     <= '0;
      flags   <= '0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      err_q <= err_n;
      oof_o <= oof_n;
      lof_o <= lof_n;
      los_q <= los_in;
      ais_q <= ais_in;
      flags <= (rd_clr ? 5'd0 : flags) | ev;
      if (reg_we && reg_addr == 2'd0) lim_sel <= reg_wdata[7];
      if (reg_we && reg_addr == 2'd1) ien <= reg_wdata[4:0];
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {lim_sel, lof_o, oof_o, los_q, ais_q, pldu_in, tmark_in, ferf_in};
      2'd1:    reg_rdata = {3'b000, ien};
      2'd2:    reg_rdata = {3'b000, flags};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign align_hold = (st == ST_LOCK) || (st == ST_OOF);
  assign irq_o      = |(flags & ien);
  assign unused_wd  = ^reg_wdata[6:5];

endmodule

// File: rtl/e3_align_supervisor_chk.sv
module e3_align_supervisor_chk #(
  parameter int LIM_LONG = 24,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frm_tick,
  input logic          oof_o,
  input logic          lof_o,
  input logic          align_hold,
  input logic [4:0]    flags,
  input logic [CW-1:0] cnt
);

  AST_LOF_IMPLIES_OOF: assert property (@(posedge clk) disable iff (!rst_n)
    lof_o |-> oof_o); // R6

  AST_HOLD_KEPT_IN_OOF: assert property (@(posedge clk) disable iff (!rst_n)
    (oof_o && !$past(oof_o)) |-> align_hold); // R3

  AST_LOF_DROPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof_o) |-> !align_hold); // R6

  AST_OOF_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (oof_o != $past(oof_o)) |-> flags[3]); // R7

  AST_LOF_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (lof_o != $past(lof_o)) |-> flags[2]); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < LIM_LONG); // R5

  AST_QUIET_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frm_tick) |-> ($stable(oof_o) && $stable(lof_o))); // R11

endmodule

bind e3_align_supervisor e3_align_supervisor_chk #(.LIM_LONG(LIM_LONG), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_tick(frm_tick), .oof_o(oof_o), .lof_o(lof_o),
  .align_hold(align_hold), .flags(flags), .cnt(cnt)
);

// File: tb/sim_e3_align_supervisor.sv
`timescale 1ns/1ps
module sim_e3_align_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_tick = 0, fa_ok = 0, pos_moved = 0;
  logic los_in = 0, ais_in = 0, pldu_in = 0, tmark_in = 0, ferf_in = 0;
  logic reg_we = 0, reg_re = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic oof_o, lof_o, align_hold, irq_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  e3_align_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .frm_tick(frm_tick), .fa_ok(fa_ok), .pos_moved(pos_moved),
    .los_in(los_in), .ais_in(ais_in), .pldu_in(pldu_in), .tmark_in(tmark_in), .ferf_in(ferf_in),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .oof_o(oof_o), .lof_o(lof_o), .align_hold(align_hold), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic ok);
    @(negedge clk); frm_tick = 1; fa_ok = ok;
    @(negedge clk); frm_tick = 0; fa_ok = 0;
  endtask

  task automatic frames(input int n, input logic ok);
    for (int i = 0; i < n; i++) frame(ok);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_re = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 oof", oof_o, 1); chk("R1 lof", lof_o, 1);
    chk("R1 hold", align_hold, 0); chk("R1 irq", irq_o, 0);
    rd(2, d); chk("R1 flags", d, 0);
    rd(1, d); chk("R1 enables", d, 0);
    rd(0, d); chk("R1 cfg", d[7:5], 3'b011);
  endtask

  task automatic t_acquire;
    logic [7:0] d;
    frame(1); frame(0);
    chk("R2 miss while confirming", {oof_o, align_hold}, 2'b10);
    frame(1); frame(1);
    chk("R2 locked", {oof_o, lof_o, align_hold}, 3'b001);
    rd(2, d); chk("R7 oof+lof change", d, 8'h0C);
    rd(2, d); chk("R8 cleared by read", d, 8'h00);
  endtask

  task automatic t_single_error;
    logic [7:0] d;
    frame(0);
    chk("R3 single error ignored", oof_o, 0);
    frame(1); frame(0); frame(0);
    chk("R3 two errors enter oof", {oof_o, lof_o, align_hold}, 3'b101);
    rd(2, d); chk("R7 oof flag only", d, 8'h08);
  endtask

  task automatic t_recover_long;
    logic [7:0] d;
    frames(23, 0);
    chk("R5 no lof before tick 24", lof_o, 0);
    frame(1);
    chk("R4 recovery on tick 24", {oof_o, lof_o, align_hold}, 3'b001);
    rd(2, d);
  endtask

  task automatic t_lof_long;
    logic [7:0] d;
    frames(2, 0);
    rd(2, d);
    frames(23, 0);
    chk("R5 long limit not reached", {lof_o, align_hold}, 2'b01);
    frame(0);
    chk("R6 lof declared", {oof_o, lof_o, align_hold}, 3'b110);
    rd(2, d); chk("R7 lof flag", d, 8'h04);
    frames(2, 1);
  endtask

  task automatic t_short;
    logic [7:0] d;
    wr(0, 8'h80);
    rd(0, d); chk("R10 limit select readback", d[7], 1);
    rd(2, d);
    frames(2, 0); frames(7, 0);
    chk("R5 short limit not reached", lof_o, 0);
    frame(1);
    chk("R4 recovery on tick 8", oof_o, 0);
    frames(2, 0); frames(7, 0);
    chk("R5 counter restarts at entry", lof_o, 0);
    frame(0);
    chk("R5 short limit lof", {oof_o, lof_o}, 2'b11);
    frames(2, 1);
    rd(2, d);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d;
    wr(1, 8'h08);
    frame(0);
    @(negedge clk); frm_tick = 1; fa_ok = 0; reg_re = 1; reg_addr = 2;
    #1 d = reg_rdata;
    @(negedge clk); frm_tick = 0; reg_re = 0;
    chk("R8 read data before edge", d, 8'h00);
    chk("R3 oof via same-cycle tick", oof_o, 1);
    chk("R9 irq enabled flag", irq_o, 1);
    rd(2, d); chk("R8 flag survives same-edge clear", d, 8'h08);
    chk("R9 irq drops after clear", irq_o, 0);
    wr(1, 8'h00);
    frame(1);
    chk("R9 irq masked", irq_o, 0);
    wr(1, 8'h08);
    chk("R9 irq on enable", irq_o, 1);
    rd(2, d);
    wr(2, 8'hFF);
    rd(2, d); chk("R8 write to flags ignored", d, 8'h00);
    wr(1, 8'hFF);
    rd(1, d); chk("R9 enable width", d, 8'h1F);
  endtask

  task automatic t_side;
    logic [7:0] d;
    @(negedge clk); los_in = 1;
    @(negedge clk);
    rd(2, d); chk("R7 los change", d, 8'h02);
    @(negedge clk); ais_in = 1;
    @(negedge clk);
    rd(2, d); chk("R7 ais change", d, 8'h01);
    pldu_in = 1; tmark_in = 1; ferf_in = 1;
    rd(0, d); chk("R10 status readback", d, 8'h9F);
  endtask

  task automatic t_cofa;
    logic [7:0] d;
    frames(2, 0); frames(8, 0);
    chk("R6 lof before cofa", lof_o, 1);
    rd(2, d);
    pos_moved = 1;
    frames(2, 1);
    pos_moved = 0;
    repeat (3) @(negedge clk);
    chk("R11 level stable between ticks", {oof_o, lof_o}, 2'b00);
    rd(2, d); chk("R7 cofa with level changes", d, 8'h1C);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_acquire();
    t_single_error();
    t_recover_long();
    t_lof_long();
    t_short();
    t_same_cycle();
    t_side();
    t_cofa();
    finish_run();
  end
endmodule